// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked request port and an asynchronous 2K x 8 static RAM that has active-low select, output-enable and write-enable strobes and one shared bidirectional data bus. Each request carries one word. A request is offered with a valid/ready handshake, together with an address, write data and a write flag. For a read, the block returns the word with a single-cycle valid pulse. For a write, acceptance completes the exchange and no response follows.

The block drives the memory address, the three strobes, the outgoing data value and the enable of its own bus driver. The sequencer walks through a fixed series of phases. Each phase lasts the smallest whole number of clock cycles that covers the memory's nanosecond limit for that phase, and never less than one cycle. The clock period is a parameter, so the same code meets the memory's limits at any clock rate. Bus direction changes only after the memory has had its worst-case release time to let go of the bus.

Top module: `sram_access_ctl`

## Requirements
- R1: After a synchronous active-high reset, select, output enable and write enable are high, the bus driver is off, `reqReady` is high and `rspValid` is low.
- R2: `reqReady` is high only while no access is in progress. A request is taken in a cycle where `reqValid` and `reqReady` are both high. No second request is taken until the current access has returned to idle.
- R3: A read holds select low, output enable low and write enable high for RD cycles, where RD is the largest of the cycle counts for the 10 ns cycle time, the 8 ns address access and the 4 ns output-enable access. All strobes return high in the next cycle.
- R4: Read data is sampled in the last cycle of the read phase. It appears on `rspData` in the following cycle, with `rspValid` high for exactly that one cycle.
- R5: A write first spends the cycle count of the 0 ns address setup (at least one cycle) with select low, write enable high and the driver on. It then holds write enable low for the largest of the cycle counts for the 5 ns pulse width, the 3.5 ns data setup and the 5 ns address-to-end-of-write limit.
- R6: After write enable rises, select stays low and the driver stays on for one more cycle. Select then stays low for any extra cycles needed to reach the 7 ns write cycle. Output enable stays high for the whole write.
- R7: Once select and output enable rise at the end of a read, the bus driver stays off for HZ cycles, where HZ covers the larger of the 3.5 ns and 4 ns release times. A write accepted during that window waits, with the strobes high, until the window has passed.
- R8: `memAddr` equals the accepted request address with no change to any bit (bits 3:0 select the column and bits 10:4 select the row) and is held for the whole access. `memDout` carries the accepted write data.
- R9: The bus driver is never on while output enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block can take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 11 | Word address |
| reqWdata | input | 8 | Write data |
| rspValid | output | 1 | One-cycle read-data strobe |
| rspData | output | 8 | Read data |
| memAddr | output | 11 | Address to the memory |
| memCsN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memDout | output | 8 | Value for the controller's bus driver |
| memDoutEn | output | 1 | Bus driver enable |
| memDin | input | 8 | Value read from the shared bus |

## Verification
The bench targets a write that arrives directly after a read. A design that ignored the release window would turn its driver on while the memory still held the bus, and the per-cycle strobe comparison would show the driver enable one or more cycles early. The bench's memory model returns valid data only in the final cycle of the read phase, so a read sampled one cycle early returns a junk byte. Back-to-back writes and reads at addresses 0 and 2047 expose a shortened write-enable pulse, a missing hold cycle with the driver still on, or an address that changes during an access. Each of these faults appears as a mismatch in the strobe pattern or in the written value when the location is read back.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_WRECOV,
    ST_READ
  } ctlState_e;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic loadReq;
    logic capture;
    logic rspPulse;
    logic csN;
    logic oeN;
    logic weN;
    logic drvEn;
  } ctlStrobe_t;

  // Whole cycles covering a limit in picoseconds, never fewer than one
  function automatic int cyclesFor(input int limitPs, input int periodPs);
    int c;
    c = (limitPs + periodPs - 1) / periodPs;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int SETUP_C = 1,
  parameter int PULSE_C = 2,
  parameter int RECOV_C = 0,
  parameter int READ_C  = 4,
  parameter int HZ_C    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output ctlStrobe_t ctl
);

  localparam int MAX_C = maxOf(maxOf(SETUP_C, PULSE_C), maxOf(READ_C, maxOf(RECOV_C, 1)));
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam int HZ_W  = $clog2(HZ_C + 1);

  ctlState_e        state, stateNext;
  logic [CNT_W-1:0] phaseCnt;
  logic [HZ_W-1:0]  relCnt;
  logic             accept;
  logic             phaseDone;

  function automatic logic [CNT_W-1:0] phaseLen(input ctlState_e s);
    case (s)
      ST_WSETUP: phaseLen = CNT_W'(SETUP_C - 1);
      ST_WPULSE: phaseLen = CNT_W'(PULSE_C - 1);
      ST_WRECOV: phaseLen = CNT_W'(maxOf(RECOV_C, 1) - 1);
      ST_READ:   phaseLen = CNT_W'(READ_C - 1);
      default:   phaseLen = '0;
    endcase
  endfunction

  assign accept    = (state == ST_IDLE) && reqValid;
  assign phaseDone = (phaseCnt == '0);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          if (!reqWrite)           stateNext = ST_READ;
          else if (relCnt > HZ_W'(1)) stateNext = ST_TURN;
          else                     stateNext = ST_WSETUP;
        end
      end
      ST_TURN:   if (relCnt <= HZ_W'(1)) stateNext = ST_WSETUP;
      ST_WSETUP: if (phaseDone) stateNext = ST_WPULSE;
      ST_WPULSE: if (phaseDone) stateNext = ST_WHOLD;
      ST_WHOLD:  stateNext = (RECOV_C > 0) ? ST_WRECOV : ST_IDLE;
      ST_WRECOV: if (phaseDone) stateNext = ST_IDLE;
      ST_READ:   if (phaseDone) stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      relCnt   <= '0;
    end else begin
      state <= stateNext;
      if (stateNext != state)  phaseCnt <= phaseLen(stateNext);
      else if (!phaseDone)     phaseCnt <= phaseCnt - 1'b1;
      if (state == ST_READ && phaseDone) relCnt <= HZ_W'(HZ_C);
      else if (relCnt != '0)             relCnt <= relCnt - 1'b1;
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.loadReq  = accept;
    ctl.capture  = (state == ST_READ) && phaseDone;
    ctl.rspPulse = (state == ST_READ) && phaseDone;
    ctl.csN      = !(state inside {ST_WSETUP, ST_WPULSE, ST_WHOLD, ST_WRECOV, ST_READ});
    ctl.oeN      = (state != ST_READ);
    ctl.weN      = (state != ST_WPULSE);
    ctl.drvEn    = state inside {ST_WSETUP, ST_WPULSE, ST_WHOLD};
  end

  assign reqReady = (state == ST_IDLE);

endmodule

// File: rtl/sram_ctl_datapath.sv
module sram_ctl_datapath
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic [DATA_W-1:0] rdataReg;
  logic              rspReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrReg  <= '0;
      wdataReg <= '0;
      rdataReg <= '0;
      rspReg   <= 1'b0;
    end else begin
      if (ctl.loadReq) begin
        addrReg  <= reqAddr;
        wdataReg <= reqWdata;
      end
      if (ctl.capture) rdataReg <= memDin;
      rspReg <= ctl.rspPulse;
    end
  end

  assign memAddr   = addrReg;
  assign memDout   = wdataReg;
  assign memDoutEn = ctl.drvEn;
  assign memCsN    = ctl.csN;
  assign memOeN    = ctl.oeN;
  assign memWeN    = ctl.weN;
  assign rspValid  = rspReg;
  assign rspData   = rdataReg;

endmodule

// File: rtl/sram_access_ctl.sv
module sram_access_ctl
  import sram_ctl_pkg::*;
#(
  parameter int COL_W         = 4,
  parameter int ROW_W         = 7,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_PS = 2500,
  parameter int T_ADDR_SU_PS  = 0,
  parameter int T_WE_PULSE_PS = 5000,
  parameter int T_DATA_SU_PS  = 3500,
  parameter int T_ADDR_END_PS = 5000,
  parameter int T_WCYC_PS     = 7000,
  parameter int T_RCYC_PS     = 10000,
  parameter int T_ADDR_ACC_PS = 8000,
  parameter int T_OE_ACC_PS   = 4000,
  parameter int T_OE_REL_PS   = 3500,
  parameter int T_CS_REL_PS   = 4000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic                    reqWrite,
  input  logic [COL_W+ROW_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]       reqWdata,
  output logic                    rspValid,
  output logic [DATA_W-1:0]       rspData,
  output logic [COL_W+ROW_W-1:0]  memAddr,
  output logic                    memCsN,
  output logic                    memOeN,
  output logic                    memWeN,
  output logic [DATA_W-1:0]       memDout,
  output logic                    memDoutEn,
  input  logic [DATA_W-1:0]       memDin
);

  localparam int ADDR_W  = COL_W + ROW_W;
  localparam int SETUP_C = cyclesFor(T_ADDR_SU_PS, CLK_PERIOD_PS);
  localparam int PULSE_C = maxOf(cyclesFor(T_WE_PULSE_PS, CLK_PERIOD_PS),
                           maxOf(cyclesFor(T_DATA_SU_PS, CLK_PERIOD_PS),
                                 cyclesFor(T_ADDR_END_PS, CLK_PERIOD_PS)));
  localparam int WCYC_C  = cyclesFor(T_WCYC_PS, CLK_PERIOD_PS);
  localparam int RECOV_C = maxOf(0, WCYC_C - SETUP_C - PULSE_C - 1);
  localparam int READ_C  = maxOf(cyclesFor(T_RCYC_PS, CLK_PERIOD_PS),
                           maxOf(cyclesFor(T_ADDR_ACC_PS, CLK_PERIOD_PS),
                                 cyclesFor(T_OE_ACC_PS, CLK_PERIOD_PS)));
  localparam int HZ_C    = maxOf(cyclesFor(T_OE_REL_PS, CLK_PERIOD_PS),
                                 cyclesFor(T_CS_REL_PS, CLK_PERIOD_PS));

  ctlStrobe_t ctl;

  sram_ctl_fsm #(
    .SETUP_C(SETUP_C), .PULSE_C(PULSE_C), .RECOV_C(RECOV_C),
    .READ_C(READ_C),   .HZ_C(HZ_C)
  ) u_fsm (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .ctl(ctl)
  );

  sram_ctl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .memDin(memDin), .memAddr(memAddr), .memDout(memDout), .memDoutEn(memDoutEn),
    .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN),
    .rspValid(rspValid), .rspData(rspData)
  );

endmodule

// File: rtl/sram_access_ctl_chk.sv
module sram_access_ctl_chk #(
  parameter int ADDR_W = 11,
  parameter int HZ_C   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              reqReady,
  input logic              rspValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCsN,
  input logic              memOeN,
  input logic              memWeN,
  input logic              memDoutEn
);

  localparam int SW = $clog2(HZ_C + 1) + 1;

  logic          seenRst;
  logic [SW-1:0] sinceOe;

  always_ff @(posedge clk) begin
    if (rst) begin
      seenRst <= 1'b1;
      sinceOe <= SW'(HZ_C);
    end else if (!memOeN) begin
      sinceOe <= '0;
    end else if (sinceOe < SW'(HZ_C)) begin
      sinceOe <= sinceOe + 1'b1;
    end
  end

  // R1: first cycle out of reset is idle
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!seenRst)
    $fell(rst) |-> (memCsN && memOeN && memWeN && !memDoutEn && reqReady && !rspValid));

  // R2: ready only when the memory is deselected
  a_r2_ready_idle: assert property (@(posedge clk) disable iff (rst || !seenRst)
    reqReady |-> memCsN);

  // R4: response is a single-cycle pulse
  a_r4_rsp_pulse: assert property (@(posedge clk) disable iff (rst || !seenRst)
    rspValid |=> !rspValid);

  // R5: write enable falls only after a select-low setup cycle
  a_r5_we_setup: assert property (@(posedge clk) disable iff (rst || !seenRst)
    $fell(memWeN) |-> ($past(!memCsN) && $past(memDoutEn)));

  // R6: driver still on in the cycle write enable rises
  a_r6_hold_drive: assert property (@(posedge clk) disable iff (rst || !seenRst)
    $rose(memWeN) |-> (memDoutEn && !memCsN));

  // R7: driver waits out the release window after a read
  a_r7_turnaround: assert property (@(posedge clk) disable iff (rst || !seenRst)
    memDoutEn |-> (sinceOe >= SW'(HZ_C)));

  // R8: address steady while select stays low
  a_r8_addr_stable: assert property (@(posedge clk) disable iff (rst || !seenRst)
    (!memCsN && $past(!memCsN)) |-> $stable(memAddr));

  // R9: no contention on the shared bus
  a_r9_no_contention: assert property (@(posedge clk) disable iff (rst || !seenRst)
    memDoutEn |-> memOeN);

endmodule

bind sram_access_ctl sram_access_ctl_chk #(.ADDR_W(ADDR_W), .HZ_C(HZ_C)) u_chk (
  .clk(clk), .rst(rst), .reqReady(reqReady), .rspValid(rspValid),
  .memAddr(memAddr), .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN),
  .memDoutEn(memDoutEn)
);

// File: tb/sim_sram_access_ctl.sv
module sim_sram_access_ctl;

  // The design is configured for a 2.5 ns period; only cycle counts matter here.
  localparam int PER_PS = 2500;

  function automatic int cyc(input int ps);
    int c;
    c = (ps + PER_PS - 1) / PER_PS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int SU  = cyc(0);
  localparam int PW  = mx(cyc(5000), mx(cyc(3500), cyc(5000)));
  localparam int REC = mx(0, cyc(7000) - SU - PW - 1);
  localparam int RD  = mx(cyc(10000), mx(cyc(8000), cyc(4000)));
  localparam int HZ  = mx(cyc(3500), cyc(4000));

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [10:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqReady, rspValid, memCsN, memOeN, memWeN, memDoutEn;
  logic [7:0]  rspData, memDout, memDin;
  logic [10:0] memAddr;

  always #5 clk = ~clk;

  sram_access_ctl u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .memAddr(memAddr),
    .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN),
    .memDout(memDout), .memDoutEn(memDoutEn), .memDin(memDin)
  );

  // Behavioural memory: data valid only in the last cycle of a full read phase
  logic [7:0] memArr [0:2047];
  logic [7:0] golden [0:2047];
  int oeLowCnt = 0;
  initial for (int i = 0; i < 2048; i++) begin
    memArr[i] = 8'(i * 7 + 3);
    golden[i] = 8'(i * 7 + 3);
  end
  assign memDin = (!memCsN && !memOeN && memWeN && oeLowCnt >= RD - 1) ? memArr[memAddr] : 8'h5A;
  always @(posedge clk) begin
    oeLowCnt <= (!memCsN && !memOeN) ? oeLowCnt + 1 : 0;
    if (!memCsN && !memWeN) memArr[memAddr] <= memDoutEn ? memDout : 8'hC3;
  end

  // Reference model: one expected entry per cycle
  typedef struct {
    bit csN, oeN, weN, drv, rdy, rsp, chkAddr;
    logic [10:0] addr;
    logic [7:0]  data;
    string       tag;
  } exp_t;
  exp_t q[$];
  int cycNo = 0;
  int lastRel = -1000;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  function automatic exp_t mk(bit cs, bit oe, bit we, bit drv, bit rdy, bit rsp, bit ca,
                              logic [10:0] a, logic [7:0] d, string t);
    exp_t e;
    e.csN = cs; e.oeN = oe; e.weN = we; e.drv = drv; e.rdy = rdy; e.rsp = rsp;
    e.chkAddr = ca; e.addr = a; e.data = d; e.tag = t;
    return e;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      lastRel = -1000;
    end else begin
      bit wasReady;
      wasReady = (q.size() == 0) || q[0].rdy;
      if (q.size() > 0) void'(q.pop_front());
      if (wasReady && reqValid) begin
        if (!reqWrite) begin
          for (int k = 0; k < RD; k++) q.push_back(mk(0,0,1,0,0,0,1,reqAddr,8'h00,"R3"));
          q.push_back(mk(1,1,1,0,1,1,0,reqAddr,golden[reqAddr],"R4"));
          lastRel = cycNo + RD + 1;
        end else begin
          int start;
          start = mx(cycNo + 1, lastRel + HZ);
          for (int k = cycNo + 1; k < start; k++) q.push_back(mk(1,1,1,0,0,0,0,reqAddr,8'h00,"R7"));
          for (int k = 0; k < SU; k++) q.push_back(mk(0,1,1,1,0,0,1,reqAddr,reqWdata,"R5"));
          for (int k = 0; k < PW; k++) q.push_back(mk(0,1,0,1,0,0,1,reqAddr,reqWdata,"R5"));
          q.push_back(mk(0,1,1,1,0,0,1,reqAddr,reqWdata,"R6"));
          for (int k = 0; k < REC; k++) q.push_back(mk(0,1,1,0,0,0,1,reqAddr,reqWdata,"R6"));
          golden[reqAddr] = reqWdata;
        end
      end
    end
    cycNo++;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      exp_t e;
      logic [5:0] act, expv;
      e = (q.size() > 0) ? q[0] : mk(1,1,1,0,1,0,0,11'h0,8'h00,"R2");
      act  = {memCsN, memOeN, memWeN, memDoutEn, reqReady, rspValid};
      expv = {e.csN, e.oeN, e.weN, e.drv, e.rdy, e.rsp};
      check(act == expv, e.tag, "strobes cs/oe/we/drv/rdy/rsp", 16'(act), 16'(expv));
      if (e.chkAddr) check(memAddr == e.addr, "R8", "memAddr", 16'(memAddr), 16'(e.addr));
      if (e.drv) check(memDout == e.data, "R8", "memDout", 16'(memDout), 16'(e.data));
      if (e.rsp) check(rspData == e.data, "R4", "rspData", 16'(rspData), 16'(e.data));
      if (memDoutEn) check(memOeN == 1'b1, "R9", "oe while driving", 16'(memOeN), 16'h1);
    end
  end

  task automatic req(input bit w, input logic [10:0] a, input logic [7:0] d);
    bit rdy;
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqWdata = d;
    do begin
      @(negedge clk); rdy = reqReady;
      @(posedge clk);
    end while (!rdy);
    #1 reqValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    check(memCsN && memOeN && memWeN, "R1", "strobes after reset",
          16'({memCsN, memOeN, memWeN}), 16'h7);
    check(!memDoutEn && reqReady && !rspValid, "R1", "drv/ready/rsp after reset",
          16'({memDoutEn, reqReady, rspValid}), 16'h2);
    @(posedge clk); #1;
    // R5 R6 R8: back-to-back writes at both address ends
    req(1, 11'h000, 8'h11);
    req(1, 11'h7FF, 8'hEE);
    req(1, 11'h3A5, 8'h5C);
    // R3 R4: back-to-back reads
    req(0, 11'h7FF, 8'h00);
    req(0, 11'h000, 8'h00);
    req(0, 11'h3A5, 8'h00);
    // R7: write straight after a read, then read it back
    req(0, 11'h010, 8'h00);
    req(1, 11'h123, 8'hA7);
    req(0, 11'h123, 8'h00);
    // R7: write one cycle later than the earliest possible one
    req(0, 11'h44F, 8'h00);
    idle(1);
    req(1, 11'h44F, 8'h3C);
    idle(HZ + 2);
    // R2: unwritten location and a write after a long idle
    req(0, 11'h600, 8'h00);
    idle(HZ + 3);
    req(1, 11'h601, 8'h99);
    req(0, 11'h601, 8'h00);
    req(0, 11'h44F, 8'h00);
    idle(RD + 8);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule